// File: doc/BRIEF.md
# Next-Program-Counter Unit

This block decides where a 32-bit RISC core with fixed 4-byte instructions fetches next. It takes the address of the current instruction, two register operands, a 16-bit signed word offset, a 26-bit jump index and a 4-bit flow code. From these it returns the next fetch address and a redirect flag. The flow code selects one of three actions: fall through, jump unconditionally, or branch when a condition holds. Each condition either compares the two operands for equality or tests the first operand's sign against zero.

Targets never carry their two low address bits, because every instruction sits on a 4-byte boundary. A branch target is taken relative to the sequential address. A jump target is spliced into the 256 MiB region of the sequential address. The conditional codes come in complementary pairs that differ only in bit 0. A compiler can therefore build a far conditional branch by selecting the opposite condition to skip over an unconditional jump.

The unit is purely combinational. Instruction fetch and delay-slot handling belong to the surrounding pipeline.

Top module: `nxp_unit`

## Requirements
- R1: Flow code 4'd0 (fall through) gives next PC = PC+4 (modulo 2^32) and redirect low.
- R2: Flow code 4'd1 (jump) always redirects. The next PC is {(PC+4)[31:28], index[25:0], 2'b00}.
- R3: Flow code 4'd2 branches when A equals B and code 4'd3 branches when they differ. This includes B = 0, which is used for branch-if-zero and branch-if-nonzero.
- R4: Flow code 4'd4 branches when A is negative as a signed value. Code 4'd5 branches when A is zero or positive.
- R5: Flow code 4'd6 branches when A is strictly positive as a signed value. Code 4'd7 branches when A is zero or negative.
- R6: For any operands, conditional codes 2/3, 4/5 and 6/7 give opposite redirect values. Bit 0 inverts the condition.
- R7: A taken branch goes to PC+4 + (sign-extended offset << 2), modulo 2^32. Offsets 16'h8000 and 16'h7FFF reach -131072 and +131068 bytes from PC+4.
- R8: Whenever redirect is low, the next PC equals PC+4. Redirect is high only for a jump or a taken branch.
- R9: Flow codes 4'd8 to 4'd15 are reserved and act as fall through: next PC = PC+4, redirect low, whatever the other inputs are.
- R10: The four region bits of a jump come from PC+4, not from PC. At PC = 32'h0FFFFFFC a jump lands in region 4'h1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| opa_i | input | 32 | First register operand (A) |
| opb_i | input | 32 | Second register operand (B) |
| boff_i | input | 16 | Signed branch offset in words |
| jidx_i | input | 26 | Jump word index within the region |
| flow_i | input | 4 | Flow code: 0 fall through, 1 jump, 2..7 conditions, 8..15 reserved |
| next_pc_o | output | 32 | Next fetch address |
| redirect_o | output | 1 | High when the next PC comes from a jump or a taken branch |

## Verification
Random operands tell the equality conditions apart from the sign conditions. Directed edge values are added on top: zero, the most negative and the most positive words, and A equal to B with B zero. These separate the strict sign tests from the non-strict ones at zero. Each random case is also replayed with bit 0 of the flow code flipped, to confirm that the paired conditions are exact complements.

The extreme offsets and a PC near the top of the address space show whether the offset is sign-extended correctly and whether the address wraps. A jump issued at the last word of a 256 MiB region shows whether the region bits come from PC+4 rather than PC. Every reserved code is driven with values that would redirect if it were decoded.

// File: rtl/nxp_pkg.sv
package nxp_pkg;

    // Flow codes: conditional pairs differ only in bit 0
    localparam logic [3:0] FLOW_SEQ  = 4'd0;
    localparam logic [3:0] FLOW_JUMP = 4'd1;
    localparam logic [3:0] FLOW_EQ   = 4'd2;
    localparam logic [3:0] FLOW_NE   = 4'd3;
    localparam logic [3:0] FLOW_LTZ  = 4'd4;
    localparam logic [3:0] FLOW_GEZ  = 4'd5;
    localparam logic [3:0] FLOW_GTZ  = 4'd6;
    localparam logic [3:0] FLOW_LEZ  = 4'd7;

    typedef enum logic [1:0] {
        TEST_EQ  = 2'd0,
        TEST_NEG = 2'd1,
        TEST_POS = 2'd2,
        TEST_NONE = 2'd3
    } cond_test_e;

    typedef struct packed {
        logic       is_jump;
        logic       is_cond;
        cond_test_e test;
        logic       invert;
    } flow_dec_t;

    function automatic flow_dec_t decode_flow(input logic [3:0] code);
        flow_dec_t d;
        d.is_jump = 1'b0;
        d.is_cond = 1'b0;
        d.test    = TEST_NONE;
        d.invert  = 1'b0;
        if (!code[3]) begin
            if (code == FLOW_JUMP) begin
                d.is_jump = 1'b1;
            end else if (code[2:1] != 2'b00) begin
                d.is_cond = 1'b1;
                d.test    = cond_test_e'(code[2:1] - 2'd1);
                d.invert  = code[0];
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/nxp_cond_eval.sv
module nxp_cond_eval
    import nxp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  cond_test_e      test_i,
    input  logic            invert_i,
    output logic            hit_o
);
    logic is_equal;
    logic a_neg;
    logic a_zero;
    logic raw;

    assign is_equal = (opa_i == opb_i);
    assign a_neg    = opa_i[XLEN-1];
    assign a_zero   = (opa_i == '0);

    always_comb begin
        unique case (test_i)
            TEST_EQ:  raw = is_equal;
            TEST_NEG: raw = a_neg;
            TEST_POS: raw = !a_neg && !a_zero;
            default:  raw = 1'b0;
        endcase
    end

    // Inversion yields the exact complement for every test
    assign hit_o = raw ^ invert_i;
endmodule

// File: rtl/nxp_target_gen.sv
module nxp_target_gen #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] boff_i,
    input  logic [IDX_W-1:0] jidx_i,
    output logic [XLEN-1:0]  seq_pc_o,
    output logic [XLEN-1:0]  br_pc_o,
    output logic [XLEN-1:0]  jmp_pc_o
);
    localparam int ALIGN  = 2;
    localparam int STEP   = 1 << ALIGN;
    localparam int EXT_W  = XLEN - OFF_W - ALIGN;
    localparam int REGN_W = XLEN - IDX_W - ALIGN;

    logic [XLEN-1:0] byte_off;

    assign seq_pc_o = pc_i + XLEN'(STEP);
    assign byte_off = {{EXT_W{boff_i[OFF_W-1]}}, boff_i, {ALIGN{1'b0}}};
    assign br_pc_o  = seq_pc_o + byte_off;

    generate
        if (REGN_W > 0) begin : g_region
            assign jmp_pc_o = {seq_pc_o[XLEN-1 -: REGN_W], jidx_i, {ALIGN{1'b0}}};
        end else begin : g_flat
            assign jmp_pc_o = {jidx_i[XLEN-ALIGN-1:0], {ALIGN{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/nxp_select.sv
module nxp_select
    import nxp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_dec_t       dec_i,
    input  logic            hit_i,
    input  logic [XLEN-1:0] seq_pc_i,
    input  logic [XLEN-1:0] br_pc_i,
    input  logic [XLEN-1:0] jmp_pc_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            redirect_o
);
    always_comb begin
        next_pc_o  = seq_pc_i;
        redirect_o = 1'b0;
        if (dec_i.is_jump) begin
            next_pc_o  = jmp_pc_i;
            redirect_o = 1'b1;
        end else if (dec_i.is_cond && hit_i) begin
            next_pc_o  = br_pc_i;
            redirect_o = 1'b1;
        end
    end
endmodule

// File: rtl/nxp_unit.sv
module nxp_unit
    import nxp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    input  logic [OFF_W-1:0] boff_i,
    input  logic [IDX_W-1:0] jidx_i,
    input  logic [3:0]       flow_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             redirect_o
);
    flow_dec_t       dec;
    logic            hit;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;

    assign dec = decode_flow(flow_i);

    nxp_cond_eval #(.XLEN(XLEN)) u_cond (
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .test_i   (dec.test),
        .invert_i (dec.invert),
        .hit_o    (hit)
    );

    nxp_target_gen #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
        .pc_i     (pc_i),
        .boff_i   (boff_i),
        .jidx_i   (jidx_i),
        .seq_pc_o (seq_pc),
        .br_pc_o  (br_pc),
        .jmp_pc_o (jmp_pc)
    );

    nxp_select #(.XLEN(XLEN)) u_sel (
        .dec_i      (dec),
        .hit_i      (hit),
        .seq_pc_i   (seq_pc),
        .br_pc_i    (br_pc),
        .jmp_pc_i   (jmp_pc),
        .next_pc_o  (next_pc_o),
        .redirect_o (redirect_o)
    );
endmodule

// File: rtl/nxp_unit_chk.sv
module nxp_unit_chk #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input logic [XLEN-1:0]  pc_i,
    input logic [XLEN-1:0]  opa_i,
    input logic [XLEN-1:0]  opb_i,
    input logic [OFF_W-1:0] boff_i,
    input logic [IDX_W-1:0] jidx_i,
    input logic [3:0]       flow_i,
    input logic [XLEN-1:0]  next_pc_o,
    input logic             redirect_o
);
    localparam int RW = XLEN - IDX_W - 2;

    logic [XLEN-1:0] c_seq;
    logic [XLEN-1:0] c_off;
    logic            c_neg;
    logic            c_zero;

    assign c_seq  = pc_i + XLEN'(4);
    assign c_off  = XLEN'($signed(boff_i)) << 2;
    assign c_neg  = $signed(opa_i) < 0;
    assign c_zero = (opa_i == '0);

    always_comb begin
        // R1
        seq_path_chk: assert (flow_i != 4'd0 || (!redirect_o && next_pc_o == c_seq));
        // R2
        jump_target_chk: assert (flow_i != 4'd1 ||
            (redirect_o && next_pc_o == {c_seq[XLEN-1 -: RW], jidx_i, 2'b00}));
        // R3
        eq_cond_chk: assert (flow_i != 4'd2 || redirect_o == (opa_i == opb_i));
        // R3
        ne_cond_chk: assert (flow_i != 4'd3 || redirect_o == (opa_i != opb_i));
        // R4
        ltz_cond_chk: assert (flow_i != 4'd4 || redirect_o == c_neg);
        // R5
        gtz_cond_chk: assert (flow_i != 4'd6 || redirect_o == (!c_neg && !c_zero));
        // R7
        branch_target_chk: assert (!(flow_i[3] == 1'b0 && flow_i[2:1] != 2'b00 && redirect_o) ||
            next_pc_o == c_seq + c_off);
        // R8
        fallthrough_chk: assert (redirect_o || next_pc_o == c_seq);
        // R9
        reserved_code_chk: assert (!flow_i[3] || (!redirect_o && next_pc_o == c_seq));
    end
endmodule

bind nxp_unit nxp_unit_chk #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
    .pc_i       (pc_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .boff_i     (boff_i),
    .jidx_i     (jidx_i),
    .flow_i     (flow_i),
    .next_pc_o  (next_pc_o),
    .redirect_o (redirect_o)
);

// File: tb/nxp_unit_bench.sv
module nxp_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc, opa, opb;
    logic [15:0] boff;
    logic [25:0] jidx;
    logic [3:0]  flow;
    logic [31:0] next_pc;
    logic        redirect;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    nxp_unit u_nxp_unit (
        .pc_i(pc), .opa_i(opa), .opb_i(opb), .boff_i(boff),
        .jidx_i(jidx), .flow_i(flow), .next_pc_o(next_pc), .redirect_o(redirect)
    );

    // Reference model built from the requirement list
    function automatic logic model_taken(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        case (f)
            4'd1:    return 1'b1;
            4'd2:    return a == b;
            4'd3:    return a != b;
            4'd4:    return $signed(a) < 0;
            4'd5:    return $signed(a) >= 0;
            4'd6:    return $signed(a) > 0;
            4'd7:    return $signed(a) <= 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_next(input logic [3:0] f, input logic [31:0] p,
                                               input logic [31:0] a, input logic [31:0] b,
                                               input logic [15:0] o, input logic [25:0] j);
        logic [31:0] nxt;
        nxt = p + 32'd4;
        if (f == 4'd1) return {nxt[31:28], j, 2'b00};
        if (model_taken(f, a, b)) return nxt + {{14{o[15]}}, o, 2'b00};
        return nxt;
    endfunction

    task automatic apply(input logic [31:0] p, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] o, input logic [25:0] j, input logic [3:0] f,
                         input string req);
        logic [31:0] e_pc;
        logic        e_tk;
        @(negedge clk);
        pc = p; opa = a; opb = b; boff = o; jidx = j; flow = f;
        e_pc = model_next(f, p, a, b, o, j);
        e_tk = model_taken(f, a, b);
        @(posedge clk);
        #1;
        checks++;
        if (next_pc !== e_pc || redirect !== e_tk) begin
            fails++;
            $display("FAIL %s code=%0d: got pc=%h redir=%b, expected pc=%h redir=%b",
                     req, f, next_pc, redirect, e_pc, e_tk);
        end
    endtask

    // R6: bit 0 of a conditional code must flip the redirect decision
    task automatic pair_check(input logic [31:0] a, input logic [31:0] b, input logic [3:0] f);
        logic first;
        apply(32'h0040_0000, a, b, 16'h0010, 26'h0, f, "R6");
        first = redirect;
        apply(32'h0040_0000, a, b, 16'h0010, 26'h0, f ^ 4'd1, "R6");
        checks++;
        if (redirect === first) begin
            fails++;
            $display("FAIL R6 codes %0d/%0d: got both %b, expected opposite", f, f ^ 4'd1, first);
        end
    endtask

    always @(posedge clk) begin
        if (rst) cycles <= 0;
        else     cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        pc = '0; opa = '0; opb = '0; boff = '0; jidx = '0; flow = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1: idle inputs after reset
        apply(32'h0, 32'h0, 32'h0, 16'h0, 26'h0, 4'd0, "R1");
        apply(32'hFFFF_FFFC, 32'h5, 32'h5, 16'h7, 26'h3, 4'd0, "R1");
        // R2, R10: jumps and region bits from PC+4
        apply(32'h1234_5678, 32'h0, 32'h0, 16'h0, 26'h3FF_FFFF, 4'd1, "R2");
        apply(32'h0FFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h000_0040, 4'd1, "R10");
        // R3: equality incl. zero B
        apply(32'h100, 32'h0, 32'h0, 16'h4, 26'h0, 4'd2, "R3");
        apply(32'h100, 32'h9, 32'h0, 16'h4, 26'h0, 4'd2, "R3");
        apply(32'h100, 32'h9, 32'h0, 16'h4, 26'h0, 4'd3, "R3");
        apply(32'h100, 32'h0, 32'h0, 16'h4, 26'h0, 4'd3, "R3");
        // R4, R5: sign tests at the edges
        apply(32'h200, 32'h8000_0000, 32'h0, 16'hFFFF, 26'h0, 4'd4, "R4");
        apply(32'h200, 32'h0, 32'h0, 16'hFFFF, 26'h0, 4'd4, "R4");
        apply(32'h200, 32'h0, 32'h0, 16'hFFFF, 26'h0, 4'd5, "R4");
        apply(32'h200, 32'h7FFF_FFFF, 32'h0, 16'h1, 26'h0, 4'd6, "R5");
        apply(32'h200, 32'h0, 32'h0, 16'h1, 26'h0, 4'd6, "R5");
        apply(32'h200, 32'h0, 32'h0, 16'h1, 26'h0, 4'd7, "R5");
        apply(32'h200, 32'hFFFF_FFFF, 32'h0, 16'h1, 26'h0, 4'd7, "R5");
        // R7: extreme offsets and wrap
        apply(32'h0010_0000, 32'h1, 32'h1, 16'h8000, 26'h0, 4'd2, "R7");
        apply(32'h0010_0000, 32'h1, 32'h1, 16'h7FFF, 26'h0, 4'd2, "R7");
        apply(32'hFFFF_FFF8, 32'h1, 32'h1, 16'h0004, 26'h0, 4'd2, "R7");
        // R8: untaken branch falls through
        apply(32'h300, 32'h1, 32'h2, 16'h7FFF, 26'h0, 4'd2, "R8");
        // R9: reserved codes with inputs that would redirect
        for (int c = 8; c < 16; c++)
            apply(32'h400, 32'h0, 32'h0, 16'h0100, 26'h3FF_FFFF, 4'(c), "R9");
        // R6: directed complement pairs
        pair_check(32'h0, 32'h0, 4'd2);
        pair_check(32'h0, 32'h0, 4'd4);
        pair_check(32'h0, 32'h0, 4'd6);

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] rp, ra, rb;
            logic [3:0]  rf;
            rp = $urandom() & 32'hFFFF_FFFC;
            ra = $urandom();
            rb = ($urandom() % 4 == 0) ? ra : $urandom();
            if ($urandom() % 8 == 0) ra = 32'h0;
            rf = 4'($urandom());
            apply(rp, ra, rb, 16'($urandom()), 26'($urandom()), rf,
                  rf == 4'd0 ? "R1" : rf == 4'd1 ? "R2" : rf < 4'd4 ? "R3" :
                  rf < 4'd6 ? "R4" : rf < 4'd8 ? "R5" : "R9");
            if (rf inside {[4'd2:4'd7]}) pair_check(ra, rb, rf);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule